// File: doc/BRIEF.md
# Rotating-Permutation Load-Balancing Crossbar (First Stage)

This block is the front half of a two-stage load-balanced packet switch. It has eight input ports and eight middle ports. Each input port fills a small local queue with whole packets of 32 sixteen-bit words, which is 64 bytes. Time is cut into slots of 32 clock cycles. In every slot, a fixed cyclic permutation joins each input to a different middle port. The permutation moves on by one position at each slot boundary. Over eight slots every input therefore visits every middle port exactly once, and offered load spreads evenly across the middle ports whatever destinations the packets carry.

An input whose queue holds a finished packet when a slot begins sends that packet whole during the slot. Otherwise it sends an idle slot. Each transmitted packet carries its final destination port and an 8-bit sequence number. That number counts packets per pair of input port and destination port. With it, the stage behind this block can put back in order packets that took different middle paths. The current slot number is also driven out, so downstream logic knows which input each middle port carries.

Top module: `lbx_top`

## Requirements
- R1: After reset, `out_slot` reads 0. It then advances by one, modulo 8, after every 32 clock cycles, and it holds its value inside a slot.
- R2: While `out_slot` equals s, middle port m carries only traffic from input port (m - s) mod 8. Put the other way, input i is joined to middle port (i + s) mod 8.
- R3: A dispatched packet leaves as 32 consecutive valid cycles in the order it was written, word 0 to word 31. Its first word appears on the first cycle of an output slot.
- R4: An input with no complete packet queued when a slot starts keeps `out_valid` low on its middle port for the whole slot. During such a slot `out_dst` and `out_seq` read 0 on that port.
- R5: Packets from one input port leave in the order they were accepted, and none are lost or duplicated.
- R6: Each input keeps one 8-bit counter per destination port, each reset to 0. A packet carries the counter's current value on `out_seq`. The counter then increments, wrapping from 255 to 0. The value is constant for the whole packet.
- R7: `out_dst` equals the destination presented on `in_dst` with the first word of the packet, and it is held for all 32 words.
- R8: Each input queue holds 4 packets. `in_rdy` is high while fewer than 4 packet buffers are full or being filled. A packet whose first word arrives while `in_rdy` is low is discarded entirely. Under line-rate traffic `in_rdy` stays high.
- R9: During reset, all `out_valid` bits are 0 and all `in_rdy` bits are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_wr | input | 8 | Per-input word strobe; the 32 strobed words of a packet may have gaps |
| in_data | input | 128 | Per-input 16-bit word, input i at bits [16i+15:16i] |
| in_dst | input | 24 | Per-input destination port, 3 bits each, sampled with the first word |
| in_rdy | output | 8 | Per-input room for another whole packet |
| out_valid | output | 8 | Per-middle-port word valid |
| out_data | output | 128 | Per-middle-port 16-bit word |
| out_dst | output | 24 | Per-middle-port destination of the packet in flight |
| out_seq | output | 64 | Per-middle-port 8-bit sequence number |
| out_slot | output | 3 | Slot number that applies to the current output cycle |

## Verification
Slot-level invariants are checked by the bound checkers on every cycle. Within a slot, the slot number, the valid flags, the destinations and the sequence stamps on the middle ports may change only at the slot boundary. In addition, no queue may hold more than four packets, and a full queue must drop `in_rdy`. Only the bench's scenarios can show the end-to-end properties. These are the correct input-to-middle mapping for each slot, word order and completeness across hundreds of packets, per-flow sequence numbers including the 255 to 0 wrap, and idle slots for an empty input.

// File: rtl/lbx_pkg.sv
package lbx_pkg;

  typedef enum logic [1:0] {
    WR_IDLE = 2'd0,
    WR_FILL = 2'd1,
    WR_SKIP = 2'd2
  } lbx_wr_mode_e;

  // Input feeding middle port m while slot s is active.
  function automatic int lbx_rot_src(input int m, input int s, input int n);
    return (m + n - s) % n;
  endfunction

endpackage

// File: rtl/lbx_slot_timer.sv
module lbx_slot_timer #(
  parameter int SLOT_CYC = 32,
  parameter int NPORT    = 8,
  localparam int WIDX_W  = $clog2(SLOT_CYC),
  localparam int SLOT_W  = $clog2(NPORT)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [WIDX_W-1:0] cyc_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              slot_start_o,
  output logic              slot_last_o
);

  logic [WIDX_W-1:0] cyc_q, cyc_d;
  logic [SLOT_W-1:0] slot_q, slot_d;

  always_comb begin
    cyc_d  = cyc_q + WIDX_W'(1);
    slot_d = slot_q;
    if (cyc_q == WIDX_W'(SLOT_CYC - 1)) begin
      cyc_d = '0;
      if (slot_q == SLOT_W'(NPORT - 1)) slot_d = '0;
      else                              slot_d = slot_q + SLOT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      slot_q <= '0;
    end else begin
      cyc_q  <= cyc_d;
      slot_q <= slot_d;
    end
  end

  assign cyc_o        = cyc_q;
  assign slot_o       = slot_q;
  assign slot_start_o = (cyc_q == '0);
  assign slot_last_o  = (cyc_q == WIDX_W'(SLOT_CYC - 1));

endmodule

// File: rtl/lbx_in_queue.sv
module lbx_in_queue
  import lbx_pkg::*;
#(
  parameter int NPORT    = 8,
  parameter int WORD_W   = 16,
  parameter int SLOT_CYC = 32,
  parameter int DEPTH    = 4,
  parameter int SEQ_W    = 8,
  localparam int DST_W   = $clog2(NPORT),
  localparam int WIDX_W  = $clog2(SLOT_CYC),
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int ADDR_W  = PTR_W + WIDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [DST_W-1:0]  wdst_i,
  output logic              rdy_o,
  input  logic [WIDX_W-1:0] cyc_i,
  input  logic              slot_start_i,
  input  logic              slot_last_i,
  output logic              lane_valid_o,
  output logic [WORD_W-1:0] lane_data_o,
  output logic [DST_W-1:0]  lane_dst_o,
  output logic [SEQ_W-1:0]  lane_seq_o
);

  logic [WORD_W-1:0] mem_q [DEPTH*SLOT_CYC];
  logic [DST_W-1:0]  dst_mem_q [DEPTH];
  logic [SEQ_W-1:0]  seq_q [NPORT];
  logic [SEQ_W-1:0]  seq_d [NPORT];

  lbx_wr_mode_e      mode_q, mode_d;
  logic [WIDX_W-1:0] widx_q, widx_d;
  logic [PTR_W-1:0]  head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              send_q, send_d;

  logic              mem_we, dst_we, push, pop, active;
  logic [CNT_W:0]    occupied;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [DST_W-1:0]  head_dst;

  assign occupied = {1'b0, cnt_q} + (CNT_W+1)'(mode_q == WR_FILL);
  assign rdy_o    = (occupied < (CNT_W+1)'(DEPTH));
  assign waddr    = {tail_q, widx_q};
  assign raddr    = {head_q, cyc_i};
  assign head_dst = dst_mem_q[head_q];
  assign active   = slot_start_i ? (cnt_q != '0) : send_q;
  assign pop      = active && slot_last_i;

  // Writer: collects one packet at a time, or skips a refused one.
  always_comb begin
    mode_d = mode_q;
    widx_d = widx_q;
    tail_d = tail_q;
    mem_we = 1'b0;
    dst_we = 1'b0;
    push   = 1'b0;
    if (wr_i) begin
      unique case (mode_q)
        WR_IDLE: begin
          widx_d = WIDX_W'(1);
          if (rdy_o) begin
            mem_we = 1'b1;
            dst_we = 1'b1;
            mode_d = WR_FILL;
          end else begin
            mode_d = WR_SKIP;
          end
        end
        WR_FILL: begin
          mem_we = 1'b1;
          if (widx_q == WIDX_W'(SLOT_CYC - 1)) begin
            push   = 1'b1;
            mode_d = WR_IDLE;
            widx_d = '0;
            tail_d = tail_q + PTR_W'(1);
          end else begin
            widx_d = widx_q + WIDX_W'(1);
          end
        end
        default: begin
          if (widx_q == WIDX_W'(SLOT_CYC - 1)) begin
            mode_d = WR_IDLE;
            widx_d = '0;
          end else begin
            widx_d = widx_q + WIDX_W'(1);
          end
        end
      endcase
    end
  end

  // Reader and per-destination sequence table.
  always_comb begin
    send_d = active;
    head_d = head_q;
    for (int d = 0; d < NPORT; d++) seq_d[d] = seq_q[d];
    if (pop) begin
      head_d           = head_q + PTR_W'(1);
      seq_d[head_dst]  = seq_q[head_dst] + SEQ_W'(1);
    end
    cnt_d = cnt_q + CNT_W'(push) - CNT_W'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= WR_IDLE;
      widx_q <= '0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      send_q <= 1'b0;
      for (int d = 0; d < NPORT; d++) seq_q[d] <= '0;
    end else begin
      mode_q <= mode_d;
      widx_q <= widx_d;
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
      send_q <= send_d;
      for (int d = 0; d < NPORT; d++) seq_q[d] <= seq_d[d];
    end
  end

  // Packet storage carries no reset.
  always_ff @(posedge clk) begin
    if (mem_we) mem_q[waddr]      <= wdata_i;
    if (dst_we) dst_mem_q[tail_q] <= wdst_i;
  end

  assign lane_valid_o = active;
  assign lane_data_o  = active ? mem_q[raddr]    : '0;
  assign lane_dst_o   = active ? head_dst        : '0;
  assign lane_seq_o   = active ? seq_q[head_dst] : '0;

endmodule

// File: rtl/lbx_rotator.sv
module lbx_rotator
  import lbx_pkg::*;
#(
  parameter int NPORT   = 8,
  parameter int WORD_W  = 16,
  parameter int SEQ_W   = 8,
  localparam int DST_W  = $clog2(NPORT),
  localparam int SLOT_W = $clog2(NPORT)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SLOT_W-1:0]       slot_i,
  input  logic [NPORT-1:0]        lane_valid_i,
  input  logic [NPORT*WORD_W-1:0] lane_data_i,
  input  logic [NPORT*DST_W-1:0]  lane_dst_i,
  input  logic [NPORT*SEQ_W-1:0]  lane_seq_i,
  output logic [NPORT-1:0]        out_valid_o,
  output logic [NPORT*WORD_W-1:0] out_data_o,
  output logic [NPORT*DST_W-1:0]  out_dst_o,
  output logic [NPORT*SEQ_W-1:0]  out_seq_o,
  output logic [SLOT_W-1:0]       out_slot_o
);

  logic [NPORT-1:0]        valid_d;
  logic [NPORT*WORD_W-1:0] data_d;
  logic [NPORT*DST_W-1:0]  dst_d;
  logic [NPORT*SEQ_W-1:0]  seq_d;

  for (genvar m = 0; m < NPORT; m++) begin : g_mid
    logic [SLOT_W-1:0] src;
    always_comb begin
      src                         = SLOT_W'(lbx_rot_src(m, int'(slot_i), NPORT));
      valid_d[m]                  = lane_valid_i[src];
      data_d[m*WORD_W +: WORD_W]  = lane_data_i[src*WORD_W +: WORD_W];
      dst_d[m*DST_W +: DST_W]     = lane_dst_i[src*DST_W +: DST_W];
      seq_d[m*SEQ_W +: SEQ_W]     = lane_seq_i[src*SEQ_W +: SEQ_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= '0;
      out_data_o  <= '0;
      out_dst_o   <= '0;
      out_seq_o   <= '0;
      out_slot_o  <= '0;
    end else begin
      out_valid_o <= valid_d;
      out_data_o  <= data_d;
      out_dst_o   <= dst_d;
      out_seq_o   <= seq_d;
      out_slot_o  <= slot_i;
    end
  end

endmodule

// File: rtl/lbx_top.sv
module lbx_top #(
  parameter int NPORT    = 8,
  parameter int WORD_W   = 16,
  parameter int SLOT_CYC = 32,
  parameter int DEPTH    = 4,
  parameter int SEQ_W    = 8,
  localparam int DST_W   = $clog2(NPORT),
  localparam int SLOT_W  = $clog2(NPORT),
  localparam int WIDX_W  = $clog2(SLOT_CYC)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPORT-1:0]        in_wr,
  input  logic [NPORT*WORD_W-1:0] in_data,
  input  logic [NPORT*DST_W-1:0]  in_dst,
  output logic [NPORT-1:0]        in_rdy,
  output logic [NPORT-1:0]        out_valid,
  output logic [NPORT*WORD_W-1:0] out_data,
  output logic [NPORT*DST_W-1:0]  out_dst,
  output logic [NPORT*SEQ_W-1:0]  out_seq,
  output logic [SLOT_W-1:0]       out_slot
);

  logic [WIDX_W-1:0]       cyc_q;
  logic [SLOT_W-1:0]       slot_q;
  logic                    slot_start, slot_last;
  logic [NPORT-1:0]        lane_valid;
  logic [NPORT*WORD_W-1:0] lane_data;
  logic [NPORT*DST_W-1:0]  lane_dst;
  logic [NPORT*SEQ_W-1:0]  lane_seq;

  lbx_slot_timer #(.SLOT_CYC(SLOT_CYC), .NPORT(NPORT)) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .cyc_o        (cyc_q),
    .slot_o       (slot_q),
    .slot_start_o (slot_start),
    .slot_last_o  (slot_last)
  );

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    lbx_in_queue #(
      .NPORT(NPORT), .WORD_W(WORD_W), .SLOT_CYC(SLOT_CYC),
      .DEPTH(DEPTH), .SEQ_W(SEQ_W)
    ) u_q (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_i         (in_wr[i]),
      .wdata_i      (in_data[i*WORD_W +: WORD_W]),
      .wdst_i       (in_dst[i*DST_W +: DST_W]),
      .rdy_o        (in_rdy[i]),
      .cyc_i        (cyc_q),
      .slot_start_i (slot_start),
      .slot_last_i  (slot_last),
      .lane_valid_o (lane_valid[i]),
      .lane_data_o  (lane_data[i*WORD_W +: WORD_W]),
      .lane_dst_o   (lane_dst[i*DST_W +: DST_W]),
      .lane_seq_o   (lane_seq[i*SEQ_W +: SEQ_W])
    );
  end

  lbx_rotator #(.NPORT(NPORT), .WORD_W(WORD_W), .SEQ_W(SEQ_W)) u_rot (
    .clk          (clk),
    .rst_n        (rst_n),
    .slot_i       (slot_q),
    .lane_valid_i (lane_valid),
    .lane_data_i  (lane_data),
    .lane_dst_i   (lane_dst),
    .lane_seq_i   (lane_seq),
    .out_valid_o  (out_valid),
    .out_data_o   (out_data),
    .out_dst_o    (out_dst),
    .out_seq_o    (out_seq),
    .out_slot_o   (out_slot)
  );

endmodule

// File: rtl/lbx_checkers.sv
module lbx_top_chk #(
  parameter int NPORT  = 8,
  parameter int SEQ_W  = 8,
  parameter int WIDX_W = 5,
  localparam int DST_W = $clog2(NPORT)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [WIDX_W-1:0]      cyc_q,
  input logic [DST_W-1:0]       out_slot,
  input logic [NPORT-1:0]       out_valid,
  input logic [NPORT*DST_W-1:0] out_dst,
  input logic [NPORT*SEQ_W-1:0] out_seq
);

  assert_slot_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q != '0) |=> $stable(out_slot));

  assert_valid_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q != '0) |=> $stable(out_valid));

  assert_dst_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q != '0) |=> $stable(out_dst));

  assert_seq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q != '0) |=> $stable(out_seq));

endmodule

module lbx_queue_chk #(
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_q,
  input logic             rdy_o,
  input logic             pop
);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  assert_full_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_W'(DEPTH)) |-> !rdy_o);

  assert_pop_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));

endmodule

bind lbx_top lbx_top_chk #(.NPORT(NPORT), .SEQ_W(SEQ_W), .WIDX_W(WIDX_W)) u_top_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cyc_q     (cyc_q),
  .out_slot  (out_slot),
  .out_valid (out_valid),
  .out_dst   (out_dst),
  .out_seq   (out_seq)
);

bind lbx_in_queue lbx_queue_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_q_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .cnt_q (cnt_q),
  .rdy_o (rdy_o),
  .pop   (pop)
);

// File: tb/lbx_top_tb_top.sv
`timescale 1ns/1ps
module lbx_top_tb_top;

  localparam int NP = 8;
  localparam int WW = 16;
  localparam int SC = 32;
  localparam int NPK = 300;

  logic            clk;
  logic            rst_n;
  logic [NP-1:0]   in_wr;
  logic [NP*WW-1:0] in_data;
  logic [NP*3-1:0] in_dst;
  logic [NP-1:0]   in_rdy;
  logic [NP-1:0]   out_valid;
  logic [NP*WW-1:0] out_data;
  logic [NP*3-1:0] out_dst;
  logic [NP*8-1:0] out_seq;
  logic [2:0]      out_slot;

  logic [WW-1:0] tb_data [NP];
  logic [2:0]    tb_dst  [NP];

  int total = 0;
  int bad   = 0;
  int exp_dst [NP][512];
  int exp_id  [NP][512];
  int wr_idx  [NP];
  int rd_idx  [NP];
  int pkt_id  [NP];
  int seq_exp [NP][NP];
  int wpos    [NP];
  int cur_src [NP];
  int delivered [NP];
  bit mon_on = 0;
  bit idle_mode = 0;
  bit finished = 0;

  lbx_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_wr(in_wr), .in_data(in_data), .in_dst(in_dst),
    .in_rdy(in_rdy), .out_valid(out_valid), .out_data(out_data), .out_dst(out_dst),
    .out_seq(out_seq), .out_slot(out_slot)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      in_data[p*WW +: WW] = tb_data[p];
      in_dst[p*3 +: 3]    = tb_dst[p];
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int word_of(input int src, input int id, input int w);
    return ((src & 7) << 13) | ((id & 255) << 5) | (w & 31);
  endfunction

  // Producer: one port, n packets, fixed destination or random (-1).
  task automatic producer(input int p, input int n, input int fdst);
    for (int k = 0; k < n; k++) begin
      int d;
      int waitc;
      d = (fdst >= 0) ? fdst : int'($urandom % NP);
      waitc = 0;
      while (!in_rdy[p] && waitc < 100) begin
        @(negedge clk);
        waitc++;
      end
      chk(in_rdy[p], "R8 in_rdy high at packet start", int'(in_rdy[p]), 1);
      exp_dst[p][wr_idx[p]] = d;
      exp_id[p][wr_idx[p]]  = pkt_id[p];
      wr_idx[p]++;
      for (int w = 0; w < SC; w++) begin
        while ($urandom % 5 == 0) begin
          in_wr[p] = 1'b0;
          @(negedge clk);
        end
        in_wr[p]   = 1'b1;
        tb_data[p] = WW'(word_of(p, pkt_id[p], w));
        tb_dst[p]  = 3'(d);
        @(negedge clk);
      end
      in_wr[p] = 1'b0;
      pkt_id[p]++;
      if ($urandom % 3 == 0) repeat ($urandom % 40) @(negedge clk);
    end
  endtask

  // Slot monitor (R1) and middle-port scoreboard (R2..R7).
  int  last_slot;
  int  age;
  bit  first_change;
  always @(negedge clk) begin
    if (mon_on && !finished) begin
      if (int'(out_slot) != last_slot) begin
        chk(int'(out_slot) == (last_slot + 1) % NP, "R1 slot step", int'(out_slot), (last_slot + 1) % NP);
        if (!first_change) chk(age == SC, "R1 slot length", age, SC);
        first_change = 1'b0;
        last_slot = int'(out_slot);
        age = 1;
      end else begin
        age++;
      end
      for (int m = 0; m < NP; m++) begin
        int src;
        int od;
        int os;
        int dat;
        src = (m + NP - int'(out_slot)) % NP;
        od  = int'(out_dst[m*3 +: 3]);
        os  = int'(out_seq[m*8 +: 8]);
        dat = int'(out_data[m*WW +: WW]);
        if (idle_mode) chk(!out_valid[m], "R4 idle slot valid low", int'(out_valid[m]), 0);
        if (out_valid[m]) begin
          if (wpos[m] == 0) begin
            cur_src[m] = src;
            chk(age == 1, "R3 packet aligned to slot start", age, 1);
            chk(rd_idx[src] < wr_idx[src], "R5 packet expected from source", rd_idx[src], wr_idx[src]);
          end
          chk(src == cur_src[m], "R2 source stable within packet", src, cur_src[m]);
          if (rd_idx[src] < wr_idx[src]) begin
            int ed;
            ed = exp_dst[src][rd_idx[src]];
            chk(dat == word_of(src, exp_id[src][rd_idx[src]], wpos[m]),
                "R2/R3/R5 word content", dat, word_of(src, exp_id[src][rd_idx[src]], wpos[m]));
            chk(od == ed, "R7 destination", od, ed);
            chk(os == seq_exp[src][ed], "R6 sequence stamp", os, seq_exp[src][ed]);
          end
          wpos[m]++;
          if (wpos[m] == SC) begin
            if (rd_idx[src] < wr_idx[src]) begin
              seq_exp[src][exp_dst[src][rd_idx[src]]] = (seq_exp[src][exp_dst[src][rd_idx[src]]] + 1) % 256;
              rd_idx[src]++;
            end
            delivered[src]++;
            wpos[m] = 0;
          end
        end else begin
          chk(wpos[m] == 0, "R3 no gap inside packet", wpos[m], 0);
          wpos[m] = 0;
          chk(od == 0 && os == 0, "R4 idle port dst/seq zero", od + os, 0);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "watchdog expired", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    in_wr = '0;
    for (int p = 0; p < NP; p++) begin
      tb_data[p] = '0; tb_dst[p] = '0;
      wr_idx[p] = 0; rd_idx[p] = 0; pkt_id[p] = 0; wpos[p] = 0;
      cur_src[p] = 0; delivered[p] = 0;
      for (int d = 0; d < NP; d++) seq_exp[p][d] = 0;
    end
    repeat (3) @(negedge clk);
    chk(out_valid == '0, "R9 valid low in reset", int'(out_valid), 0);
    chk(in_rdy == '1, "R9 in_rdy high in reset", int'(in_rdy), 255);
    chk(out_slot == '0, "R1 slot zero in reset", int'(out_slot), 0);
    rst_n = 1'b1;
    @(negedge clk);
    last_slot = int'(out_slot);
    chk(last_slot == 0, "R1 slot zero after reset", last_slot, 0);
    age = 1;
    first_change = 1'b1;
    mon_on = 1'b1;

    // Directed: no traffic, two full rotations of idle slots.
    idle_mode = 1'b1;
    repeat (2 * NP * SC) @(negedge clk);
    idle_mode = 1'b0;

    // Directed: one packet on input 3 to destination 5.
    producer(3, 1, 5);
    repeat (2 * SC + 2) @(negedge clk);
    chk(delivered[3] == 1, "R4 single packet sent in next slot", delivered[3], 1);

    // Random traffic; input 0 always targets 2 to wrap its sequence counter.
    for (int p = 0; p < NP; p++) begin
      automatic int pp = p;
      fork
        producer(pp, NPK, (pp == 0) ? 2 : -1);
      join_none
    end
    wait fork;
    repeat (4 * SC) @(negedge clk);

    for (int p = 0; p < NP; p++)
      chk(rd_idx[p] == wr_idx[p], "R5 all packets delivered", rd_idx[p], wr_idx[p]);
    chk(seq_exp[0][2] == NPK % 256, "R6 sequence wrapped on input 0", seq_exp[0][2], NPK % 256);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule